// File: doc/BRIEF.md
# SPI Flash Page-Program Receiver

This block sits on the slave side of a four-wire serial bus in SPI mode 0. It runs on a fast system clock, with the bus clock, chip enable and data input arriving asynchronously. Each pin passes through a two-flop synchronizer, and the receiver detects edges in the system domain. The system clock must be at least four times the bus clock. A data bit is taken on each rising bus clock while chip enable is low, most significant bit first. Raising chip enable closes the command.

The receiver enforces a two-command write sequence. First comes a stand-alone 8-bit enable command, which sets a write-enable latch. After chip enable has stayed high for at least a minimum gap, a program transaction follows: an 8-bit opcode, a 24-bit address and one data byte. When the sequence is legal, the block emits a one-cycle write strobe toward the memory side, carrying the address and the data. Two sticky flags report sequence violations: a program command with no enable before it, and a chip-enable gap that is too short.

The memory-side output is valid-only, with no ready. The serial master never waits, so back-pressure is not possible. The sink must accept every single-cycle strobe, and address and data hold their values until the next strobe.

Top module: `flash_pgm_rx`

## Requirements
- R1: After reset, `wel`, `wr_valid`, `err_seq` and `err_gap` are all 0.
- R2: A command of exactly 8 bits equal to `EN_OP` (default 0x06) sets `wel` when chip enable rises. Bits are sampled on rising `sck` and arrive MSB first.
- R3: These leave `wel` clear: an enable command with any bit count other than 8, and any other 8-bit opcode. The bit count restarts at every falling edge of chip enable.
- R4: A complete program transaction writes when `wel` is set and the gap was long enough. The transaction is exactly 40 bits: `PG_OP` (default 0x02), a 24-bit address, then one data byte. `wr_valid` is then high for exactly one cycle, on the third clock edge after `cs_n` rises, with `wr_addr` and `wr_data`.
- R5: The first address byte after the opcode becomes `wr_addr[23:16]`, the second `wr_addr[15:8]` and the third `wr_addr[7:0]`. The final byte becomes `wr_data`.
- R6: A program command received while `wel` is clear writes nothing and sets `err_seq`.
- R7: Before a program command, `cs_n` must stay high for at least ceil(`MIN_GAP_NS`/`CLK_PERIOD_NS`) clocks (40 by default). With a shorter gap, nothing is written and `err_gap` is set. A gap of exactly the minimum is accepted.
- R8: Any transaction of 8 or more bits that opens with the program opcode clears `wel`. If its bit count is not 40, nothing is written.
- R9: `err_seq` and `err_gap` stay set until reset, whatever transactions follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bus clock, idles low |
| cs_n | input | 1 | Chip enable, active low |
| mosi | input | 1 | Serial data from master |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_addr | output | 24 | Write address, held between strobes |
| wr_data | output | 8 | Write data, held between strobes |
| wel | output | 1 | Write-enable latch |
| err_seq | output | 1 | Sticky: program without enable |
| err_gap | output | 1 | Sticky: chip-enable gap too short |

## Verification
Every result of a command becomes visible on the third system clock edge after `cs_n` rises: two synchronizer stages, then the registered decode. That applies to the strobe with its address and data, the enable latch and both error flags. The bench drives all pins on falling clock edges and counts falling edges after raising `cs_n`. It expects `wr_valid` low at the second, high at the third and low again at the fourth. It reads the address, data, latch and flags at the third or fourth. Chip-enable gaps are set as an exact number of clock periods, so the boundary pair of 39 and 40 clocks lands precisely on the threshold.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int OP_W       = 8;
  localparam int ADDR_W     = 24;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = OP_W + ADDR_W + DATA_W;
  localparam int PAYLOAD_W  = ADDR_W + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } fpr_wr_t;
endpackage

// File: rtl/fpr_sync.sv
module fpr_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/fpr_shift.sv
module fpr_shift
  import fpr_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_fall,
  input  logic                 cs_lo,
  input  logic                 sck_rise,
  input  logic                 mosi_bit,
  output logic [CNT_W-1:0]     bit_cnt,
  output logic [OP_W-1:0]      op_q,
  output logic [PAYLOAD_W-1:0] payload
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      op_q    <= '0;
      payload <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (sck_rise && cs_lo) begin
      payload <= {payload[PAYLOAD_W-2:0], mosi_bit};
      if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(OP_W - 1)) op_q <= {payload[OP_W-2:0], mosi_bit};
    end
  end

  // R3: every new command starts counting from zero
  a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bit_cnt == '0));
endmodule

// File: rtl/fpr_seq.sv
module fpr_seq
  import fpr_pkg::*;
#(
  parameter logic [OP_W-1:0] EN_OP   = 8'h06,
  parameter logic [OP_W-1:0] PG_OP   = 8'h02,
  parameter int              GAP_CYC = 40,
  parameter int              CNT_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_rise,
  input  logic                 cs_fall,
  input  logic                 cs_hi,
  input  logic [CNT_W-1:0]     bit_cnt,
  input  logic [OP_W-1:0]      op_q,
  input  logic [PAYLOAD_W-1:0] payload,
  output fpr_wr_t              wr_q,
  output logic                 wr_valid,
  output logic                 wel,
  output logic                 err_seq,
  output logic                 err_gap
);
  localparam int              GAP_W   = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CYC);

  logic [GAP_W-1:0] gap_cnt;
  logic             gap_short;
  logic             is_en, is_pg, pg_full;

  // CE-high duration, saturating at the minimum
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_cnt <= GAP_MAX;
    else if (cs_rise)                  gap_cnt <= GAP_W'(1);
    else if (cs_hi && gap_cnt != GAP_MAX) gap_cnt <= gap_cnt + 1'b1;
  end

  always_comb begin
    is_en   = (bit_cnt == CNT_W'(OP_W)) && (op_q == EN_OP);
    is_pg   = (bit_cnt >= CNT_W'(OP_W)) && (op_q == PG_OP);
    pg_full = is_pg && (bit_cnt == CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_short <= 1'b0;
      wr_valid  <= 1'b0;
      wr_q      <= '0;
      wel       <= 1'b0;
      err_seq   <= 1'b0;
      err_gap   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (cs_fall) gap_short <= (gap_cnt < GAP_MAX);
      if (cs_rise) begin
        if (is_en) begin
          wel <= 1'b1;
        end else if (is_pg) begin
          wel <= 1'b0;
          if (!wel)           err_seq <= 1'b1;
          else if (gap_short) err_gap <= 1'b1;
          else if (pg_full) begin
            wr_valid <= 1'b1;
            wr_q     <= fpr_wr_t'(payload);
          end
        end
      end
    end
  end

  a_r2_wel_on_ce_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r6_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(wel));
  a_r8_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wel);
  a_r9_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_seq |=> err_seq);
  a_r9_gap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_gap |=> err_gap);
endmodule

// File: rtl/flash_pgm_rx.sv
module flash_pgm_rx
  import fpr_pkg::*;
#(
  parameter int              CLK_PERIOD_NS = 5,
  parameter int              MIN_GAP_NS    = 200,
  parameter int              SYNC_STAGES   = 2,
  parameter logic [OP_W-1:0] EN_OP         = 8'h06,
  parameter logic [OP_W-1:0] PG_OP         = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wel,
  output logic              err_seq,
  output logic              err_gap
);
  localparam int GAP_CYC = (MIN_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);

  logic [2:0]           pins_s;
  logic                 sck_s, cs_s, mosi_s, sck_d, cs_d;
  logic                 sck_rise, cs_rise, cs_fall;
  logic [CNT_W-1:0]     bit_cnt;
  logic [OP_W-1:0]      op_q;
  logic [PAYLOAD_W-1:0] payload;
  fpr_wr_t              wr_q;

  fpr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, mosi}), .q(pins_s));

  assign sck_s  = pins_s[2];
  assign cs_s   = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign cs_rise  = cs_s & ~cs_d;
  assign cs_fall  = ~cs_s & cs_d;

  fpr_shift #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_lo(~cs_s),
    .sck_rise(sck_rise), .mosi_bit(mosi_s),
    .bit_cnt(bit_cnt), .op_q(op_q), .payload(payload));

  fpr_seq #(.EN_OP(EN_OP), .PG_OP(PG_OP), .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall), .cs_hi(cs_s),
    .bit_cnt(bit_cnt), .op_q(op_q), .payload(payload),
    .wr_q(wr_q), .wr_valid(wr_valid), .wel(wel),
    .err_seq(err_seq), .err_gap(err_gap));

  assign wr_addr = wr_q.addr;
  assign wr_data = wr_q.data;
endmodule

// File: tb/sim_flash_pgm_rx.sv
`timescale 1ns/1ps
module sim_flash_pgm_rx;
  localparam int HP = 4;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic wr_valid, wel, err_seq, err_gap;
  logic [23:0] wr_addr;
  logic [7:0]  wr_data;
  int n_run = 0, n_fail = 0;
  logic v2, v3, v4, wel4, es4, eg4;
  logic [23:0] a3;
  logic [7:0]  d3;

  always #2.5 clk = ~clk;

  flash_pgm_rx u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wel(wel),
    .err_seq(err_seq), .err_gap(err_gap));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // sends n bits of v MSB first; cs_n then stays high for exactly hold clocks
  task automatic tx(input logic [47:0] v, input int n, input int hold);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    mosi = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      if (k == 2) v2 = wr_valid;
      if (k == 3) begin v3 = wr_valid; a3 = wr_addr; d3 = wr_data; end
      if (k == 4) begin v4 = wr_valid; wel4 = wel; es4 = err_seq; eg4 = err_gap; end
    end
  endtask

  function automatic logic [47:0] pg_frame(input logic [23:0] a, input logic [7:0] d);
    return {8'h0, 8'h02, a, d};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 wel", wel, 0);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 err_seq", err_seq, 0);
    check("R1 err_gap", err_gap, 0);

    // R2/R3/R6: every 8-bit opcode alone
    for (int op = 0; op < 256; op++) begin
      do_reset();
      tx(48'(op), 8, 60);
      check("R2 R3 wel after opcode", wel4, (op == 8'h06));
      check("R6 err_seq after lone opcode", es4, (op == 8'h02));
    end

    // R3: enable opcode with wrong bit counts
    for (int n = 1; n <= 16; n++) begin
      logic [47:0] v;
      do_reset();
      v = (n <= 8) ? 48'(8'h06 >> (8 - n)) : (48'h06 << (n - 8));
      tx(v, n, 60);
      check("R2 R3 wel vs bit count", wel4, (n == 8));
    end

    // R4/R5/R8: write sweep
    do_reset();
    for (int i = 0; i < 24; i++) begin
      logic [23:0] a;
      logic [7:0]  d;
      a = 24'(24'h13579B * (i + 1)) ^ 24'(i << 17);
      d = 8'((i * 53 + 7) & 255);
      tx(48'h06, 8, 60);
      check("R2 wel set", wel4, 1);
      tx(pg_frame(a, d), 40, 60);
      check("R4 strobe low at edge 2", v2, 0);
      check("R4 strobe at edge 3", v3, 1);
      check("R4 strobe one cycle", v4, 0);
      check("R5 address order", a3, a);
      check("R4 data", d3, d);
      check("R8 wel cleared after write", wel4, 0);
    end

    // R6 then R9
    do_reset();
    tx(pg_frame(24'h123456, 8'h77), 40, 60);
    check("R6 no write without wel", v3, 0);
    check("R6 err_seq set", es4, 1);
    tx(48'h06, 8, 60);
    tx(pg_frame(24'h654321, 8'h88), 40, 60);
    check("R9 write after err_seq", v3, 1);
    check("R9 err_seq sticky", es4, 1);

    // R7 gap boundary
    do_reset();
    tx(48'h06, 8, 39);
    tx(pg_frame(24'hABCDEF, 8'h11), 40, 60);
    check("R7 short gap no write", v3, 0);
    check("R7 err_gap set", eg4, 1);
    check("R8 wel cleared after short gap", wel4, 0);
    tx(48'h06, 8, 60);
    tx(pg_frame(24'h0F0F0F, 8'h22), 40, 60);
    check("R9 write after err_gap", v3, 1);
    check("R9 err_gap sticky", eg4, 1);
    do_reset();
    tx(48'h06, 8, 40);
    tx(pg_frame(24'hABCDEF, 8'h11), 40, 60);
    check("R7 exact gap writes", v3, 1);
    check("R7 exact gap no error", eg4, 0);
    check("R7 address", a3, 24'hABCDEF);

    // R8: aborted program lengths
    for (int n = 8; n <= 48; n++) begin
      logic [47:0] full;
      if (n == 40) continue;
      do_reset();
      full = {8'h02, 24'hABCDEF, 8'h5A, 8'hC3};
      tx(48'h06, 8, 60);
      tx(full >> (48 - n), n, 60);
      check("R8 abort no write", v3, 0);
      check("R8 abort clears wel", wel4, 0);
      check("R8 abort no seq error", es4, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule